// File: doc/BRIEF.md
# Burst Address Generator

This block forms the memory address that one port of a synchronous RAM uses on each clock. Every rising edge it picks one of four actions. It can clear the address to zero, or load a fresh external address. It can also step its own counter by one, or keep the previous address. A port can therefore run a burst or an interleaved sweep after presenting a single starting address.

The three controls are active low and have a fixed priority. Clear beats load, and load beats step. The block has no chip-enable input, so the chosen action takes effect on every edge whatever the state of the port's selects. A clear costs no extra cycle: the access in that cycle already uses address 0. Stepping wraps to 0 once the address reaches the top of a parameterised address space (`DEPTH` locations, 65536 by default on a 16-bit bus). It also wraps to 0 when a loaded address lies beyond that top.

`cur_addr` is registered. After edge k it holds the address that the access launched at edge k uses.

Top module: `burst_addr_gen`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `cur_addr` is 0 after that edge, whatever `strobe_n`, `adv_n` and `ext_addr` are.
- R2: When `clr_n` is 1 and `strobe_n` is 0, `cur_addr` after the edge equals the `ext_addr` sampled at that edge, whatever `adv_n` is.
- R3: When `clr_n` and `strobe_n` are 1 and `adv_n` is 0, `cur_addr` after the edge is the previous value plus one, provided the previous value is below `DEPTH-1`.
- R4: When `clr_n`, `strobe_n` and `adv_n` are all 1, `cur_addr` keeps its value and `ext_addr` has no effect on it.
- R5: A step taken from address `DEPTH-1` gives 0.
- R6: A step taken from an address above `DEPTH-1` (one that was loaded) gives 0.
- R7: While the synchronous reset `rst` is 1 at an edge, `cur_addr` becomes 0 after that edge, and this overrides every other control.
- R8: When `DEPTH` equals 2^`ADDR_W`, a step from the all-ones address gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External address, used when the strobe is low |
| strobe_n | input | 1 | Address load strobe, active low |
| adv_n | input | 1 | Counter step enable, active low |
| clr_n | input | 1 | Counter clear, active low, highest priority after `rst` |
| cur_addr | output | ADDR_W | Registered internal address for the current access |

## Verification
The bench builds two instances.

The first, `uut`, uses `ADDR_W`=8 and `DEPTH`=200. That top is not a power of two, so the compare-and-clear wrap runs with only a few steps. A loaded address such as 240 lies above the top, which exercises the out-of-range step. The table walk also pairs every control against the others, so the priority of clear over load and of load over step is shown on the output.

The second instance uses `ADDR_W`=4 and `DEPTH`=16. It selects the natural-overflow variant of the incrementer, so the all-ones wrap is reached in a single step.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Action chosen for one clock edge, in priority order.
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_KEEP  = 2'd3
  } addr_op_t;

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
  import burst_addr_pkg::*;
(
  input  logic     clr_n,
  input  logic     strobe_n,
  input  logic     adv_n,
  output addr_op_t op
);

  // Fixed priority: clear, then load, then step, else keep.
  always_comb begin
    if (!clr_n)         op = OP_CLEAR;
    else if (!strobe_n) op = OP_LOAD;
    else if (!adv_n)    op = OP_STEP;
    else                op = OP_KEEP;
  end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);
  localparam bit FULL_SPACE = (DEPTH == (1 << ADDR_W));

  generate
    if (FULL_SPACE) begin : g_overflow
      // Full binary space: the carry out falls away and gives the wrap.
      assign nxt = cur + 1'b1;
    end else begin : g_compare
      // Partial space: clear at or beyond the top address.
      assign nxt = (cur >= TOP) ? '0 : cur + 1'b1;
    end
  endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              adv_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] cur_addr
);

  addr_op_t          op;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] addr_q;

  burst_addr_decode u_decode (
    .clr_n    (clr_n),
    .strobe_n (strobe_n),
    .adv_n    (adv_n),
    .op       (op)
  );

  burst_addr_step #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_step (
    .cur (addr_q),
    .nxt (stepped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else begin
      unique case (op)
        OP_CLEAR: addr_q <= '0;
        OP_LOAD:  addr_q <= ext_addr;
        OP_STEP:  addr_q <= stepped;
        OP_KEEP:  addr_q <= addr_q;
        default:  addr_q <= addr_q;
      endcase
    end
  end

  assign cur_addr = addr_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strobe_n,
  input logic              adv_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] cur_addr
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> cur_addr == '0);

  assert_load_ext_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !strobe_n) |=> cur_addr == $past(ext_addr));

  // Covers R3 below the top, and R5, R6 and R8 at or above it.
  assert_step_next_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && !adv_n) |=>
      cur_addr == (($past(cur_addr) >= TOP) ? '0 : $past(cur_addr) + 1'b1));

  assert_keep_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && adv_n) |=> $stable(cur_addr));

  assert_reset_zero_R7: assert property (@(posedge clk)
    rst |=> cur_addr == '0);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ext_addr (ext_addr),
  .strobe_n (strobe_n),
  .adv_n    (adv_n),
  .clr_n    (clr_n),
  .cur_addr (cur_addr)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

  localparam int W = 8;
  localparam int D = 200;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ext_addr = '0;
  logic         strobe_n = 1'b1;
  logic         adv_n = 1'b1;
  logic         clr_n = 1'b1;
  logic [W-1:0] cur_addr;

  logic         rst_b = 1'b1;
  logic [3:0]   ext_b = '0;
  logic         strobe_b = 1'b1;
  logic         adv_b = 1'b1;
  logic         clr_b = 1'b1;
  logic [3:0]   cur_b;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  burst_addr_gen #(.ADDR_W(W), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
    .adv_n(adv_n), .clr_n(clr_n), .cur_addr(cur_addr)
  );

  burst_addr_gen #(.ADDR_W(4), .DEPTH(16)) uut_p2 (
    .clk(clk), .rst(rst_b), .ext_addr(ext_b), .strobe_n(strobe_b),
    .adv_n(adv_b), .clr_n(clr_b), .cur_addr(cur_b)
  );

  // Each entry: {clr_n, strobe_n, adv_n, ext_addr, expected cur_addr}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {3'b101, 8'h10, 8'h10},  // R2 load
    {3'b110, 8'h00, 8'h11},  // R3 step
    {3'b110, 8'h00, 8'h12},  // R3 step
    {3'b111, 8'h55, 8'h12},  // R4 keep, ext ignored
    {3'b100, 8'h40, 8'h40},  // R2 load beats step
    {3'b000, 8'h77, 8'h00},  // R1 clear beats load and step
    {3'b110, 8'h99, 8'h01},  // R3 step from cleared value
    {3'b101, 8'hC6, 8'hC6},  // R2 load 198
    {3'b110, 8'h00, 8'hC7},  // R3 step to 199
    {3'b110, 8'h00, 8'h00},  // R5 wrap at DEPTH-1
    {3'b101, 8'hF0, 8'hF0},  // R2 load 240, beyond top
    {3'b110, 8'h00, 8'h00},  // R6 step from out of range
    {3'b011, 8'hAA, 8'h00},  // R1 clear alone
    {3'b110, 8'h00, 8'h01}   // R3 step after clear
  };

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R7: reset state, with a load request held during reset
    strobe_n = 1'b0; ext_addr = 8'h33;
    strobe_b = 1'b0; ext_b = 4'h9;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset uut", int'(cur_addr), 0);
    check("R7 reset uut_p2", int'(cur_b), 0);
    @(negedge clk);
    rst = 1'b0; rst_b = 1'b0;
    strobe_n = 1'b1; strobe_b = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {clr_n, strobe_n, adv_n, ext_addr} = VEC[i][18:8];
      @(posedge clk);
      #1;
      check($sformatf("table row %0d (R1-group tag in row comment)", i),
            int'(cur_addr), int'(VEC[i][7:0]));
    end

    // R7: reset overrides a load while running
    @(negedge clk);
    clr_n = 1'b1; strobe_n = 1'b0; adv_n = 1'b0; ext_addr = 8'h21; rst = 1'b1;
    @(posedge clk); #1;
    check("R7 reset beats load", int'(cur_addr), 0);
    @(negedge clk);
    rst = 1'b0; strobe_n = 1'b1; adv_n = 1'b1;

    // R4: several held edges with a changing external address
    @(negedge clk);
    strobe_n = 1'b0; ext_addr = 8'h5A;
    @(negedge clk);
    strobe_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      ext_addr = 8'(k * 37 + 1);
      @(posedge clk); #1;
      check("R4 keep under changing ext", int'(cur_addr), 8'h5A);
      @(negedge clk);
    end

    // R8: power-of-two space wraps from all ones
    strobe_b = 1'b0; ext_b = 4'hF;
    @(posedge clk); #1;
    check("R2 load 15 on uut_p2", int'(cur_b), 15);
    @(negedge clk);
    strobe_b = 1'b1; adv_b = 1'b0;
    @(posedge clk); #1;
    check("R8 wrap all ones", int'(cur_b), 0);
    @(negedge clk);
    strobe_b = 1'b0; ext_b = 4'h7;
    @(posedge clk); #1;
    @(negedge clk);
    strobe_b = 1'b1;
    @(posedge clk); #1;
    check("R3 step mid-range on uut_p2", int'(cur_b), 8);
    @(negedge clk);
    clr_b = 1'b0;
    @(posedge clk); #1;
    check("R1 clear on uut_p2", int'(cur_b), 0);
    @(negedge clk);
    clr_b = 1'b1; adv_b = 1'b1;

    finish_run();
  end

endmodule